// File: doc/BRIEF.md
# Transport Stream Ring Writer

This block accepts a byte-wide transport stream (one byte per cycle when `ts_valid` is high, with `ts_start` marking the first byte of a packet) and stores it into a circular buffer in host memory. Bytes are gathered into 32-bit words, least significant byte first, and each full word leaves on a single-cycle write port (`mem_we`, `mem_addr`, `mem_wdata`). The ring sits at a programmable base address and spans a programmable number of bytes. When the write offset reaches the end of the ring it wraps back to the base.

A small register set, reached by a word index on `reg_addr`, configures the block and reports its state. Index 0 holds the ring base address. Index 1 holds the ring length in bytes. Index 2 holds the packet length, 8 bits, with reset value 188. Index 3 holds the number of packets per interrupt, 8 bits, with reset value 47. Index 4 returns the write pointer and is read only. Writing bit 0 of index 5 restarts the ring. Index 6 is the interrupt mask. Index 7 is the interrupt status. Bit 0 of index 8 is the global interrupt enable.

Status bit 0 reports completed packet batches, bit 2 reports a host-command event (`ev_host`) and bit 3 reports a remote-control event (`ev_ir`). The mask uses the same bit positions. The other status and mask bits always read as zero.

Top module: `ts_ring_writer`

## Requirements
- R1: After reset the following hold. `mem_we` and `irq` are 0. Status (index 7) reads 0. The write pointer (index 4) reads 0. Packet length (index 2) reads 188. Packets per interrupt (index 3) reads 47.
- R2: After reset or a ring restart, stream bytes are discarded until a byte arrives with `ts_start` high.
- R3: Accepted bytes are packed little-endian: the first byte goes to `mem_wdata[7:0]`. Exactly one write is issued per four accepted bytes. It appears on the ports in the cycle after the fourth byte, at address base plus current offset.
- R4: After each write the offset advances by 4. The offset returns to 0 when it would reach the ring length.
- R5: Index 4 reads the absolute address of the next write, which is the base plus the offset, not the bare offset.
- R6: Bytes are counted against the packet length. Status bit 0 is set when the programmed number of packets has completed since the last batch. The packet count then restarts.
- R7: A byte with `ts_start` high always begins a new packet, even in the middle of a packet. A partial packet does not count.
- R8: A pulse on `ev_host` sets status bit 2, and a pulse on `ev_ir` sets status bit 3. An event in the same cycle as a clear still sets its bit.
- R9: Writing a value to index 7 clears exactly the status bits that are 1 in that value. The other bits are left unchanged.
- R10: `irq` is high exactly when the global enable is 1 and some status bit is also set in the mask. Mask bit 1 is not implemented and reads 0.
- R11: Writing 1 to bit 0 of index 5 returns the pointer to the base. It drops any partly filled word and resets the packet count. A byte arriving in that same cycle is lost.
- R12: The low two bits of the ring length read 0 whatever value is written, so the ring is always a whole number of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ts_data | input | 8 | Stream byte |
| ts_valid | input | 1 | Stream byte present |
| ts_start | input | 1 | Byte is the first of a packet |
| ev_host | input | 1 | Host-command event pulse |
| ev_ir | input | 1 | Remote-control event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Packed memory word |
| irq | output | 1 | Interrupt request |

## Verification
If the byte lane or the offset goes wrong, the fault shows at the ports within four accepted bytes. It appears as a wrong `mem_wdata` byte order, a wrong `mem_addr`, or a write pointer that disagrees with the last write address plus four. An error in the packet counter stays hidden until a batch should complete. It then shows as status bit 0 being set one or more packets early or late, so packets are fed with resyncs part-way through. Faults in status or mask show up in `irq` in the same cycle as the bad register value.

// File: rtl/ts_ring_pkg.sv
package ts_ring_pkg;
  localparam int IDX_W = 4;
  localparam int NSTAT = 4;

  typedef enum logic [IDX_W-1:0] {
    RG_BASE   = 4'd0,
    RG_SIZE   = 4'd1,
    RG_PKTLEN = 4'd2,
    RG_PKTIRQ = 4'd3,
    RG_WPTR   = 4'd4,
    RG_RESTART= 4'd5,
    RG_MASK   = 4'd6,
    RG_STAT   = 4'd7,
    RG_CTRL   = 4'd8
  } reg_idx_e;

  // status bit positions; bit 1 unimplemented
  localparam int ST_TS   = 0;
  localparam int ST_HOST = 2;
  localparam int ST_IR   = 3;
  localparam logic [NSTAT-1:0] STAT_IMPL = 4'b1101;
endpackage

// File: rtl/ts_byte_packer.sv
module ts_byte_packer #(
  parameter int DATA_W = 32,
  parameter int PL_W   = 8,
  parameter int IC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              byte_vld,
  input  logic              byte_start,
  input  logic [7:0]        byte_in,
  input  logic [PL_W-1:0]   pkt_len,
  input  logic [IC_W-1:0]   pkts_per_irq,
  output logic              word_fire,
  output logic [DATA_W-1:0] word_out,
  output logic              pkt_evt
);
  localparam int BPW    = DATA_W / 8;
  localparam int LANE_W = $clog2(BPW);
  localparam int SH_W   = DATA_W - 8;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BPW - 1);

  logic [LANE_W-1:0] lane_q, lane_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              sync_q, sync_d;
  logic [PL_W-1:0]   bidx_q, bidx_d, idx;
  logic [IC_W-1:0]   pcnt_q, pcnt_d;
  logic              take, pkt_end, batch_hit;
  logic [PL_W-1:0]   len_last;
  logic [IC_W-1:0]   ppi_last;

  assign len_last  = pkt_len - PL_W'(1);
  assign ppi_last  = pkts_per_irq - IC_W'(1);
  assign take      = byte_vld && (sync_q || byte_start) && !flush;
  assign idx       = byte_start ? '0 : bidx_q;
  assign pkt_end   = take && (idx == len_last);
  assign batch_hit = pcnt_q >= ppi_last;
  assign word_fire = take && (lane_q == LAST_LANE);
  assign word_out  = {byte_in, sh_q};
  assign pkt_evt   = pkt_end && batch_hit;

  always_comb begin
    lane_d = lane_q;
    sh_d   = sh_q;
    sync_d = sync_q;
    bidx_d = bidx_q;
    pcnt_d = pcnt_q;
    if (flush) begin
      lane_d = '0;
      sync_d = 1'b0;
      bidx_d = '0;
      pcnt_d = '0;
    end else if (take) begin
      sync_d = 1'b1;
      for (int i = 0; i < BPW - 1; i++) begin
        if (lane_q == LANE_W'(i)) sh_d[i*8 +: 8] = byte_in;
      end
      lane_d = word_fire ? '0 : lane_q + LANE_W'(1);
      if (pkt_end) begin
        bidx_d = '0;
        pcnt_d = batch_hit ? '0 : pcnt_q + IC_W'(1);
      end else begin
        bidx_d = idx + PL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      sh_q   <= '0;
      sync_q <= 1'b0;
      bidx_q <= '0;
      pcnt_q <= '0;
    end else begin
      lane_q <= lane_d;
      sh_q   <= sh_d;
      sync_q <= sync_d;
      bidx_q <= bidx_d;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/ts_ring_ptr.sv
module ts_ring_ptr #(
  parameter int AW     = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              word_fire,
  input  logic [DATA_W-1:0] word_in,
  input  logic [AW-1:0]     base,
  input  logic [LEN_W-1:0]  size,
  output logic [LEN_W-1:0]  off,
  output logic [AW-1:0]     wptr,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int STEP = DATA_W / 8;

  logic [LEN_W-1:0] off_q, off_d, off_inc;

  assign off_inc = off_q + LEN_W'(STEP);
  assign wptr    = base + AW'(off_q);
  assign off     = off_q;

  always_comb begin
    off_d = off_q;
    if (flush)          off_d = '0;
    else if (word_fire) off_d = (off_inc >= size) ? '0 : off_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      off_q  <= off_d;
      mem_we <= word_fire;
      if (word_fire) begin
        mem_addr  <= wptr;
        mem_wdata <= word_in;
      end
    end
  end
endmodule

// File: rtl/ts_irq_ctrl.sv
module ts_irq_ctrl
  import ts_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTAT-1:0] set_vec,
  input  logic             clr_wr,
  input  logic [NSTAT-1:0] clr_vec,
  input  logic [NSTAT-1:0] mask,
  input  logic             en,
  output logic [NSTAT-1:0] stat,
  output logic             irq
);
  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    if (STAT_IMPL[i]) begin : g_impl
      logic bit_q, bit_d;
      always_comb begin
        bit_d = bit_q;
        if (clr_wr && clr_vec[i]) bit_d = 1'b0;
        if (set_vec[i])           bit_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign stat[i] = bit_q;
    end else begin : g_none
      assign stat[i] = 1'b0;
    end
  end

  assign irq = en && |(stat & mask);
endmodule

// File: rtl/ts_ring_writer.sv
module ts_ring_writer
  import ts_ring_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DATA_W       = 32,
  parameter int LEN_W        = 24,
  parameter int PL_W         = 8,
  parameter int IC_W         = 8,
  parameter int DEF_PKT_LEN  = 188,
  parameter int DEF_PKTS_IRQ = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        ts_data,
  input  logic              ts_valid,
  input  logic              ts_start,
  input  logic              ev_host,
  input  logic              ev_ir,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq
);
  localparam int STEP = DATA_W / 8;
  localparam logic [LEN_W-1:0] SIZE_KEEP = ~LEN_W'(STEP - 1);

  logic [1:0]        sync_q;
  logic              srst_n;
  logic [AW-1:0]     base_q;
  logic [LEN_W-1:0]  size_q;
  logic [PL_W-1:0]   plen_q;
  logic [IC_W-1:0]   ppi_q;
  logic [NSTAT-1:0]  mask_q, stat_q, set_vec;
  logic              en_q, dma_rst, stat_wr, word_fire, pkt_evt;
  logic [DATA_W-1:0] word;
  logic [LEN_W-1:0]  ptr_off;
  logic [AW-1:0]     wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  assign dma_rst = reg_wr && (reg_addr == RG_RESTART) && reg_wdata[0];
  assign stat_wr = reg_wr && (reg_addr == RG_STAT);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      base_q <= '0;
      size_q <= '0;
      plen_q <= PL_W'(DEF_PKT_LEN);
      ppi_q  <= IC_W'(DEF_PKTS_IRQ);
      mask_q <= '0;
      en_q   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == RG_BASE)   base_q <= reg_wdata;
      if (reg_addr == RG_SIZE)   size_q <= reg_wdata[LEN_W-1:0] & SIZE_KEEP;
      if (reg_addr == RG_PKTLEN) plen_q <= reg_wdata[PL_W-1:0];
      if (reg_addr == RG_PKTIRQ) ppi_q  <= reg_wdata[IC_W-1:0];
      if (reg_addr == RG_MASK)   mask_q <= reg_wdata[NSTAT-1:0] & STAT_IMPL;
      if (reg_addr == RG_CTRL)   en_q   <= reg_wdata[0];
    end
  end

  ts_byte_packer #(.DATA_W(DATA_W), .PL_W(PL_W), .IC_W(IC_W)) u_pack (
    .clk(clk), .rst_n(srst_n), .flush(dma_rst),
    .byte_vld(ts_valid), .byte_start(ts_start), .byte_in(ts_data),
    .pkt_len(plen_q), .pkts_per_irq(ppi_q),
    .word_fire(word_fire), .word_out(word), .pkt_evt(pkt_evt)
  );

  ts_ring_ptr #(.AW(AW), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_ptr (
    .clk(clk), .rst_n(srst_n), .flush(dma_rst),
    .word_fire(word_fire), .word_in(word), .base(base_q), .size(size_q),
    .off(ptr_off), .wptr(wptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_TS]   = pkt_evt;
    set_vec[ST_HOST] = ev_host;
    set_vec[ST_IR]   = ev_ir;
  end

  ts_irq_ctrl u_irq (
    .clk(clk), .rst_n(srst_n), .set_vec(set_vec),
    .clr_wr(stat_wr), .clr_vec(reg_wdata[NSTAT-1:0]),
    .mask(mask_q), .en(en_q), .stat(stat_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RG_BASE:   reg_rdata = base_q;
      RG_SIZE:   reg_rdata = AW'(size_q);
      RG_PKTLEN: reg_rdata = AW'(plen_q);
      RG_PKTIRQ: reg_rdata = AW'(ppi_q);
      RG_WPTR:   reg_rdata = wptr;
      RG_MASK:   reg_rdata = AW'(mask_q);
      RG_STAT:   reg_rdata = AW'(stat_q);
      RG_CTRL:   reg_rdata = AW'(en_q);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ts_ring_chk.sv
module ts_ring_chk #(
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_rst,
  input logic [LEN_W-1:0] off,
  input logic             mem_we,
  input logic             en,
  input logic             irq,
  input logic             stat_wr,
  input logic [3:0]       clr,
  input logic [3:0]       stat,
  input logic             ev_host,
  input logic             ev_ir,
  input logic             pkt_evt
);
  a_r11_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst |=> (off == '0));

  a_r11_no_write_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst |=> !mem_we);

  a_r3_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  a_r10_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  a_r9_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !ev_host && !ev_ir && !pkt_evt) |=> ((stat & $past(clr)) == 4'b0000));

  a_r8_host_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_host |=> stat[2]);

  a_r8_ir_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ir |=> stat[3]);
endmodule

bind ts_ring_writer ts_ring_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(srst_n), .dma_rst(dma_rst), .off(ptr_off),
  .mem_we(mem_we), .en(en_q), .irq(irq), .stat_wr(stat_wr),
  .clr(reg_wdata[3:0]), .stat(stat_q), .ev_host(ev_host), .ev_ir(ev_ir),
  .pkt_evt(pkt_evt)
);

// File: tb/sim_ts_ring_writer.sv
module sim_ts_ring_writer;
  localparam int PERIOD = 10;

  logic        clk, rst_n;
  logic [7:0]  ts_data;
  logic        ts_valid, ts_start, ev_host, ev_ir, reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_wdata;
  logic        mem_we, irq;

  ts_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .ts_data(ts_data), .ts_valid(ts_valid),
    .ts_start(ts_start), .ev_host(ev_host), .ev_ir(ev_ir),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  int vectors = 0;
  int fails   = 0;
  int wcount  = 0;
  logic [31:0] cap_addr, cap_data;

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit          m_r1, m_r2, m_sync, m_en, e_we;
  int          m_off, m_lane, m_bidx, m_pcnt, m_size, m_plen, m_ppi;
  logic [31:0] m_sh, m_base, e_addr, e_data;
  logic [3:0]  m_stat, m_mask;

  task automatic model_clear();
    m_off = 0; m_lane = 0; m_sync = 0; m_bidx = 0; m_pcnt = 0;
    m_stat = 0; m_mask = 0; m_en = 0; m_base = 0; m_size = 0;
    m_plen = 188; m_ppi = 47; e_we = 0; e_addr = 0; e_data = 0; m_sh = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      model_clear();
    end else begin
      if (!m_r2) model_clear();
      else begin
        bit rstp, take, evt;
        int idx;
        logic [3:0] clr, setv;
        rstp = reg_wr && reg_addr == 4'd5 && reg_wdata[0];
        take = ts_valid && (m_sync || ts_start);
        evt = 0;
        e_we = 0;
        if (rstp) begin
          m_off = 0; m_lane = 0; m_sync = 0; m_bidx = 0; m_pcnt = 0;
        end else if (take) begin
          m_sync = 1;
          m_sh[m_lane*8 +: 8] = ts_data;
          if (m_lane == 3) begin
            e_we = 1; e_addr = m_base + m_off; e_data = m_sh;
            m_off = m_off + 4;
            if (m_off >= m_size) m_off = 0;
            m_lane = 0;
          end else m_lane++;
          idx = ts_start ? 0 : m_bidx;
          if (idx == m_plen - 1) begin
            m_bidx = 0;
            if (m_pcnt >= m_ppi - 1) begin evt = 1; m_pcnt = 0; end
            else m_pcnt++;
          end else m_bidx = idx + 1;
        end
        clr  = (reg_wr && reg_addr == 4'd7) ? reg_wdata[3:0] : 4'h0;
        setv = {ev_ir, ev_host, 1'b0, evt};
        m_stat = ((m_stat & ~clr) | setv) & 4'hD;
        if (reg_wr) begin
          case (reg_addr)
            4'd0: m_base = reg_wdata;
            4'd1: m_size = int'(reg_wdata[23:0] & 24'hFFFFFC);
            4'd2: m_plen = int'(reg_wdata[7:0]);
            4'd3: m_ppi  = int'(reg_wdata[7:0]);
            4'd6: m_mask = reg_wdata[3:0] & 4'hD;
            4'd8: m_en   = reg_wdata[0];
            default: ;
          endcase
        end
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (mem_we !== e_we) begin
        fails++; $display("FAIL R3 mem_we actual=%0b expected=%0b", mem_we, e_we);
      end else if (e_we && (mem_addr !== e_addr || mem_wdata !== e_data)) begin
        fails++; $display("FAIL R3 write actual=%h/%h expected=%h/%h",
                          mem_addr, mem_wdata, e_addr, e_data);
      end
      vectors++;
      if (irq !== (m_en && |(m_stat & m_mask))) begin
        fails++; $display("FAIL R10 irq actual=%0b expected=%0b", irq, m_en && |(m_stat & m_mask));
      end
      if (reg_addr == 4'd4) begin
        vectors++;
        if (reg_rdata !== m_base + m_off) begin
          fails++; $display("FAIL R5 wptr actual=%h expected=%h", reg_rdata, m_base + m_off);
        end
      end
      if (mem_we) begin wcount++; cap_addr = mem_addr; cap_data = mem_wdata; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input bit st);
    @(negedge clk); #1;
    ts_data = d; ts_valid = 1; ts_start = st;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; ts_valid = 0; ts_start = 0;
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    ts_valid = 0; ts_start = 0;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 0; reg_addr = 4'd4;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); #1;
    ts_valid = 0; ts_start = 0; reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = 4'd4;
  endtask

  task automatic packet(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) put(seed + 8'(i), i == 0);
  endtask

  task automatic pulse(input bit host, input bit ir);
    @(negedge clk); #1; ev_host = host; ev_ir = ir;
    @(negedge clk); #1; ev_host = 0; ev_ir = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog (all R) actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w0;
    rst_n = 0; ts_data = 0; ts_valid = 0; ts_start = 0; ev_host = 0; ev_ir = 0;
    reg_wr = 0; reg_addr = 4'd4; reg_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    idle(4);

    // R1 reset state
    chk("R1 mem_we", {31'b0, mem_we}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(4'd2, v); chk("R1 pktlen", v, 188);
    rd(4'd3, v); chk("R1 pkts/irq", v, 47);
    rd(4'd4, v); chk("R1 wptr", v, 0);
    rd(4'd7, v); chk("R1 status", v, 0);

    // configuration; R12 size rounding, R10 mask bit 1
    wreg(4'd0, 32'h1000);
    wreg(4'd1, 32'h22);
    rd(4'd1, v); chk("R12 size", v, 32'h20);
    wreg(4'd2, 12);
    wreg(4'd3, 2);
    wreg(4'd6, 32'hF);
    rd(4'd6, v); chk("R10 mask", v, 32'hD);
    wreg(4'd8, 1);

    // R2 bytes before first start are dropped
    put(8'h11, 0); put(8'h12, 0); put(8'h13, 0); idle(3);
    rd(4'd4, v); chk("R2 wptr", v, 32'h1000);
    chk("R2 writes", wcount, 0);

    // R3/R4/R6 three packets of 12 bytes, batch of 2
    packet(12, 8'h40); packet(12, 8'h60); idle(2);
    rd(4'd7, v); chk("R6 status bit0", v, 32'h1);
    chk("R6 irq", {31'b0, irq}, 1);
    packet(12, 8'h80); idle(2);
    rd(4'd4, v); chk("R4 wrap wptr", v, 32'h1004);
    chk("R3 write count", wcount, 9);

    // R9 write-back clear
    rd(4'd7, v); wreg(4'd7, v);
    rd(4'd7, v); chk("R9 cleared", v, 0);
    chk("R9 irq", {31'b0, irq}, 0);

    // R8 events, R10 gating
    pulse(1, 0); pulse(0, 1); idle(1);
    rd(4'd7, v); chk("R8 status", v, 32'hC);
    chk("R10 irq masked in", {31'b0, irq}, 1);
    wreg(4'd6, 1); idle(1); chk("R10 irq masked out", {31'b0, irq}, 0);
    wreg(4'd6, 32'hD); wreg(4'd8, 0); idle(1);
    chk("R10 irq disabled", {31'b0, irq}, 0);
    wreg(4'd8, 1); idle(1); chk("R10 irq enabled", {31'b0, irq}, 1);
    wreg(4'd7, 32'h4);
    rd(4'd7, v); chk("R9 partial clear", v, 32'h8);
    wreg(4'd7, 32'hF);

    // R7 resync mid-packet, batch of 1
    wreg(4'd3, 1);
    packet(5, 8'hB0); idle(1);
    rd(4'd7, v); chk("R7 partial no event", v, 0);
    packet(11, 8'hC0); idle(1);
    rd(4'd7, v); chk("R7 before packet end", v, 0);
    put(8'hCB, 0); idle(1);
    rd(4'd7, v); chk("R7 packet end", v, 32'h1);

    // R11 restart mid-word
    put(8'hD0, 0); put(8'hD1, 0);
    wreg(4'd5, 1);
    rd(4'd4, v); chk("R11 wptr home", v, 32'h1000);
    put(8'h99, 0); idle(1);
    w0 = wcount;
    put(8'hA0, 1); put(8'hA1, 0); put(8'hA2, 0); put(8'hA3, 0); idle(3);
    chk("R11 one write", wcount - w0, 1);
    chk("R11 addr", cap_addr, 32'h1000);
    chk("R3 byte order", cap_data, 32'hA3A2A1A0);

    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule